// File: doc/BRIEF.md
# Microcoded Subtractive GCD Engine

This block finds the greatest common divisor of two nonzero unsigned operands by repeated subtraction. The subtraction order is not wired into a state machine. It comes from a small stored microprogram, and that microprogram drives a datapath. The datapath has two working registers, a subtractor whose two operands can each be chosen from either register, an equal/greater comparator, a result register and a completion flag. The control side has four parts: a microprogram counter, a microinstruction register, a constant control store of eight 16-bit words, and a status multiplexer that feeds a three-instruction sequencer.

Each word has four fields:

- nine datapath control bits;
- a 2-bit sequencer operation: `00` continue to address plus one, `01` jump to the branch address if the selected status is true and otherwise fall through to address plus one, `10` jump unconditionally;
- a 2-bit status select: `00` start is low, `01` operands equal, `10` first operand greater;
- a 3-bit branch address.

The host keeps `opnd_a` and `opnd_b` stable and raises `go` while the engine is idle. The engine captures the operands one edge later. It signals completion by raising `done`, with the result held on `gcd_out`. There is no back-pressure. The result and `done` stay valid until the next accepted `go` clears them, so a consumer may sample them at any time after `done` rises.

With a zero operand the step loop never reaches equality. `done` then stays low until reset. Callers must not start the engine with a zero.

Top module: `gcd_mc_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `gcd_out` is 0, `done` is 0 and the controller sits at its idle word. A reset during a computation abandons the computation.
- R2: While the engine is idle and `go` is low, it stays idle, and changes on `opnd_a`/`opnd_b` leave `gcd_out` and `done` unchanged.
- R3: If `go` is high at rising edge n while the engine is idle, both operands are captured and `done` is cleared at edge n+1.
- R4: When a computation ends, `gcd_out` equals the GCD of the captured operands, and `done` rises at the same edge that loads `gcd_out`.
- R5: `done` stays low from edge n+1 until the edge that delivers the result.
- R6: With equal operands, `done` rises at edge n+3.
- R7: Each subtraction step replaces the larger register with larger minus smaller and takes three cycles. With k steps, `done` rises at edge n+3+3k.
- R8: `gcd_out` changes only at the edge where `done` rises. After completion both hold until the next accepted `go`.
- R9: `go` pulses during a computation are ignored: they change neither the result nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, sampled only at the idle word |
| opnd_a | input | DATA_W | First operand, nonzero |
| opnd_b | input | DATA_W | Second operand, nonzero |
| gcd_out | output | DATA_W | Result register |
| done | output | 1 | Completion flag, high while `gcd_out` holds a fresh result |

## Verification
The bound checker watches the microprogram counter and datapath registers on every cycle. It confirms that:
- the idle word holds while `go` is low and leaves when `go` is high;
- the equal test exits to the result word;
- each subtract word is reached only with the correct operand ordering;
- `done` is low throughout the working words;
- the result register moves only as `done` rises.

Only the bench's scenarios can show the arithmetic result against a reference GCD, the exact latency as a function of the step count, and recovery after a mid-run reset. The same holds for the absence of effects from operand changes while idle and from `go` pulses while busy.

// File: rtl/gcd_mc_pkg.sv
package gcd_mc_pkg;

  localparam int UADDR_W = 3;
  localparam int UDEPTH  = 1 << UADDR_W;

  typedef enum logic [1:0] {
    SQ_NEXT = 2'b00,
    SQ_CJMP = 2'b01,
    SQ_JMP  = 2'b10
  } seq_op_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'b00,  // go is low
    CS_EQ    = 2'b01,  // working registers equal
    CS_GT    = 2'b10,  // first register greater
    CS_NEVER = 2'b11
  } cond_sel_e;

  typedef struct packed {
    logic r1_from_diff;
    logic r2_from_diff;
    logic suba_is_r2;
    logic subb_is_r1;
    logic ld_r1;
    logic ld_r2;
    logic ld_res;
    logic clr_done;
    logic set_done;
  } dp_ctl_t;

  typedef struct packed {
    dp_ctl_t              ctl;
    seq_op_e              seq;
    cond_sel_e            cond;
    logic [UADDR_W-1:0]   na;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // Control store contents, one entry per microprogram address
  function automatic uword_t ucode(input int addr);
    uword_t w;
    w      = '0;
    w.seq  = SQ_JMP;
    w.cond = CS_NEVER;
    w.na   = '0;
    case (addr)
      0: begin w.seq = SQ_CJMP; w.cond = CS_IDLE; w.na = 3'd0; end
      1: begin
        w.ctl.ld_r1 = 1'b1; w.ctl.ld_r2 = 1'b1; w.ctl.clr_done = 1'b1;
        w.seq = SQ_NEXT;
      end
      2: begin w.seq = SQ_CJMP; w.cond = CS_EQ; w.na = 3'd6; end
      3: begin w.seq = SQ_CJMP; w.cond = CS_GT; w.na = 3'd5; end
      4: begin  // second larger: r2 := r2 - r1
        w.ctl.suba_is_r2 = 1'b1; w.ctl.subb_is_r1 = 1'b1;
        w.ctl.r2_from_diff = 1'b1; w.ctl.ld_r2 = 1'b1;
        w.seq = SQ_JMP; w.na = 3'd2;
      end
      5: begin  // first larger: r1 := r1 - r2
        w.ctl.r1_from_diff = 1'b1; w.ctl.ld_r1 = 1'b1;
        w.seq = SQ_JMP; w.na = 3'd2;
      end
      6: begin
        w.ctl.ld_res = 1'b1; w.ctl.set_done = 1'b1;
        w.seq = SQ_JMP; w.na = 3'd0;
      end
      default: begin w.seq = SQ_JMP; w.na = 3'd0; end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/gcd_mc_rom.sv
module gcd_mc_rom
  import gcd_mc_pkg::*;
(
  input  logic [UADDR_W-1:0] addr,
  output uword_t             word
);

  uword_t store [UDEPTH];

  for (genvar g = 0; g < UDEPTH; g++) begin : g_word
    assign store[g] = ucode(g);
  end

  assign word = store[addr];

endmodule

// File: rtl/gcd_mc_seq.sv
module gcd_mc_seq
  import gcd_mc_pkg::*;
(
  input  seq_op_e            seq,
  input  cond_sel_e          cond,
  input  logic [UADDR_W-1:0] na,
  input  logic [UADDR_W-1:0] upc,
  input  logic               go,
  input  logic               st_eq,
  input  logic               st_gt,
  output logic [UADDR_W-1:0] nxt
);

  logic                 sel_status;
  logic [UADDR_W-1:0]   upc_inc;

  assign upc_inc = upc + UADDR_W'(1);

  always_comb begin
    case (cond)
      CS_IDLE: sel_status = ~go;
      CS_EQ:   sel_status = st_eq;
      CS_GT:   sel_status = st_gt;
      default: sel_status = 1'b0;
    endcase
  end

  always_comb begin
    case (seq)
      SQ_CJMP: nxt = sel_status ? na : upc_inc;
      SQ_JMP:  nxt = na;
      default: nxt = upc_inc;
    endcase
  end

endmodule

// File: rtl/gcd_mc_dp.sv
module gcd_mc_dp
  import gcd_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_ctl_t           ctl,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W-1:0] r1,
  output logic [DATA_W-1:0] r2,
  output logic [DATA_W-1:0] res,
  output logic              done,
  output logic              st_eq,
  output logic              st_gt
);

  logic [DATA_W-1:0] sub_a, sub_b, diff;

  assign sub_a = ctl.suba_is_r2 ? r2 : r1;
  assign sub_b = ctl.subb_is_r1 ? r1 : r2;
  assign diff  = sub_a - sub_b;
  assign st_eq = (r1 == r2);
  assign st_gt = (r1 > r2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1   <= '0;
      r2   <= '0;
      res  <= '0;
      done <= 1'b0;
    end else begin
      if (ctl.ld_r1)    r1   <= ctl.r1_from_diff ? diff : in_a;
      if (ctl.ld_r2)    r2   <= ctl.r2_from_diff ? diff : in_b;
      if (ctl.ld_res)   res  <= r1;
      if (ctl.clr_done) done <= 1'b0;
      else if (ctl.set_done) done <= 1'b1;
    end
  end

endmodule

// File: rtl/gcd_mc_top.sv
module gcd_mc_top
  import gcd_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] gcd_out,
  output logic              done
);

  logic [UADDR_W-1:0] upc;
  logic [UADDR_W-1:0] nxt;
  uword_t             uir;
  uword_t             rom_word;
  logic [DATA_W-1:0]  r1, r2;
  logic               st_eq, st_gt;

  gcd_mc_seq u_seq (
    .seq   (uir.seq),
    .cond  (uir.cond),
    .na    (uir.na),
    .upc   (upc),
    .go    (go),
    .st_eq (st_eq),
    .st_gt (st_gt),
    .nxt   (nxt)
  );

  gcd_mc_rom u_rom (
    .addr (nxt),
    .word (rom_word)
  );

  // Microprogram counter and microinstruction register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc <= '0;
      uir <= ucode(0);
    end else begin
      upc <= nxt;
      uir <= rom_word;
    end
  end

  gcd_mc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (uir.ctl),
    .in_a  (opnd_a),
    .in_b  (opnd_b),
    .r1    (r1),
    .r2    (r2),
    .res   (gcd_out),
    .done  (done),
    .st_eq (st_eq),
    .st_gt (st_gt)
  );

endmodule

// File: rtl/gcd_mc_chk.sv
module gcd_mc_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic [2:0]        upc,
  input logic [DATA_W-1:0] r1,
  input logic [DATA_W-1:0] r2,
  input logic [DATA_W-1:0] gcd_out,
  input logic              done
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd0 && !go) |=> (upc == 3'd0));  // R2

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd0 && go) |=> (upc == 3'd1));  // R3

  AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (upc >= 3'd2) |-> !done);  // R5

  AST_EQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd2 && r1 == r2) |=> (upc == 3'd6));  // R6

  AST_SUB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd5) |-> (r1 > r2));  // R7

  AST_SUB_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd4) |-> (r1 < r2));  // R7

  AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 3'd6) |=> (upc == 3'd0 && done && gcd_out == $past(r1)));  // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(gcd_out));  // R8

endmodule

bind gcd_mc_top gcd_mc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .upc     (upc),
  .r1      (r1),
  .r2      (r2),
  .gcd_out (gcd_out),
  .done    (done)
);

// File: tb/tb_gcd_mc_top.sv
module tb_gcd_mc_top;

  localparam int W = 8;
  localparam int NVEC = 10;
  localparam int LIMIT = 2000;

  // {a, b, expected gcd}
  localparam logic [3*W-1:0] VEC [NVEC] = '{
    {8'd48,  8'd18,  8'd6},
    {8'd18,  8'd48,  8'd6},
    {8'd255, 8'd85,  8'd85},
    {8'd7,   8'd7,   8'd7},
    {8'd1,   8'd200, 8'd1},
    {8'd200, 8'd1,   8'd1},
    {8'd17,  8'd13,  8'd1},
    {8'd100, 8'd75,  8'd25},
    {8'd128, 8'd96,  8'd32},
    {8'd221, 8'd187, 8'd17}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         go = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] gcd_out;
  logic         done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gcd_mc_top #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .go(go),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .gcd_out(gcd_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic int ref_steps(input int a, input int b);
    int x = a, y = b, k = 0;
    while (x != y) begin
      if (x > y) x = x - y; else y = y - x;
      k++;
    end
    return k;
  endfunction

  task automatic run_one(input int a, input int b, input int exp, input bit poke);
    int cnt = 0;
    int k = ref_steps(a, b);
    @(negedge clk);
    opnd_a = W'(a); opnd_b = W'(b); go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 1) check(done == 1'b0, "R3 done cleared", int'(done), 0);
      if (poke && cnt == 5) go = 1'b1;
      if (poke && cnt == 6) go = 1'b0;
    end while (!done && cnt < LIMIT);
    go = 1'b0;
    check(int'(gcd_out) == exp, "R4 result", int'(gcd_out), exp);
    if (poke)        check(cnt == 3 + 3*k, "R9 latency with busy go", cnt, 3 + 3*k);
    else if (k == 0) check(cnt == 3, "R6 equal latency", cnt, 3);
    else             check(cnt == 3 + 3*k, "R7 step latency", cnt, 3 + 3*k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(gcd_out == '0, "R1 result in reset", int'(gcd_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && gcd_out == '0, "R1 after release", int'(gcd_out), 0);

    // R2: idle with go low ignores operand changes
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opnd_a = W'(i * 37 + 1); opnd_b = W'(i * 11 + 3);
    end
    @(negedge clk);
    check(done == 1'b0 && gcd_out == '0, "R2 idle unchanged", int'(gcd_out), 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      run_one(int'(VEC[i][3*W-1:2*W]), int'(VEC[i][2*W-1:W]), int'(VEC[i][W-1:0]), 1'b0);
    end

    // R8 / R2: result held after completion while idle
    held = gcd_out;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opnd_a = W'(i + 90); opnd_b = W'(i + 5);
    end
    check(gcd_out == held, "R8 result held", int'(gcd_out), int'(held));
    check(done == 1'b1, "R8 done held", int'(done), 1);

    // R9: go pulse while busy is ignored
    run_one(100, 7, 1, 1'b1);
    run_one(96, 36, 12, 1'b1);

    // Long run boundary: many steps
    run_one(255, 1, 1, 1'b0);
    run_one(1, 1, 1, 1'b0);

    // Random pairs against reference
    for (int i = 0; i < 30; i++) begin
      int a = int'($urandom_range(1, 255));
      int b = int'($urandom_range(1, 255));
      run_one(a, b, ref_gcd(a, b), 1'b0);
    end

    // R1: reset in the middle of a computation
    @(negedge clk);
    opnd_a = 8'd250; opnd_b = 8'd3; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 mid-run reset done", int'(done), 0);
    check(gcd_out == '0, "R1 mid-run reset result", int'(gcd_out), 0);
    rst_n = 1'b1;
    run_one(84, 60, 12, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule